// File: doc/BRIEF.md
# Link Power State Controller

This block follows the power state of several device functions that share one serial link. It then decides which power state that link should be in. Each function has its own tracker, which moves between off, uninitialised active, active and sleep. The tracker responds to that function's reset line, to writes of its power-state command and to its bus-master enable. The trackers are combined into one device state, and the most awake function wins. From that device state and from the traffic demand, a registered state machine picks the link state: full-on (L0), transmit standby (L0s), low-power idle (L1), auxiliary-powered (L2) or off (L3).

While the device is active, the link steps down on its own. It first enters standby after an idle run whose length comes from the partner's exit latency, optionally divided by four. It then enters low-power idle after a programmable dwell in standby. Any activity request brings the link back to full-on at the next clock edge. When every function has been reset, the controller chooses between auxiliary power and off. That choice depends on whether the device came from sleep and on whether wake signalling is enabled. A PLL-gate request output marks the states in which the link clock may be stopped.

All control inputs are plain levels or single-cycle strobes. There is no data stream, so the block has no valid/ready interface.

Top module: `lpm_link_ctrl`

## Requirements
- R1: `dev_state` shows the aggregate of the function states, using 00 off, 01 uninitialised active, 10 active and 11 sleep. It is 10 if any function is active. Otherwise it is 01 if any function is uninitialised active, otherwise 11 if any function sleeps, and otherwise 00. It follows the function states with no added delay.
- R2: Each function's tracker changes state on the clock edge that samples its inputs, as follows:
  - An asserted `fn_rst` forces the function to off.
  - An off function with `fn_rst` low goes to uninitialised active.
  - An uninitialised function with `bme` high goes to active.
  - A write of 11 to its 2-bit command slot from either active state goes to sleep. This write takes priority over `bme`.
  - A write of 00 while in sleep goes to uninitialised active.
  - Every other write has no effect.
- R3: `link_state` uses 0 for L0, 1 for L0s, 2 for L1, 3 for L2 and 4 for L3. After `rst_n` the link is L3 and `dev_state` is 00.
- R4: While the device is active, L0s is entered from L0 only if `aspm_ctl` bit 0 is 1. Entry happens on the N-th consecutive clock edge that samples `act_req` low, where N is the entry latency.
- R5: The entry latency is `partner_exit_lat` when `ent_lat_sel` is 0. When `ent_lat_sel` is 1 it is that value shifted right by two. A result of zero is raised to 1.
- R6: Whenever the device is active and `act_req` is high in L0s or L1, the next edge returns the link to L0. The idle timers restart after the request.
- R7: From L0s with `aspm_ctl` bit 1 set and `l1_cap` high, the link enters L1 on the M-th edge after entering L0s, where M is `l1_dwell` (zero is raised to 1). A device state of sleep puts the link in L1 on the next edge.
- R8: With `l1_cap` low, the link never enters L1 while the device is active.
- R9: When the device state becomes off, the next edge selects the link's off state. The link goes to L2 if the device state in the previous cycle was sleep and `pme_en` is high. Otherwise it goes to L3. L2 and L3 hold while the device stays off, and the link returns to L0 once the device is active.
- R10: `pll_gate_req` is high in L1 or L2 when `pll_gate_dis` is low, and low in every other case.
- R11: When the device leaves sleep for an active state, the link goes from L1 to L0 on the next edge, even with no activity request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| fn_rst | input | NUM_FN | Per-function reset, high = asserted |
| pm_wr_en | input | NUM_FN | Per-function power-state write strobe |
| pm_wr_data | input | 2*NUM_FN | Power-state command, two bits per function (function i at [2i+1:2i]) |
| bme | input | NUM_FN | Per-function bus-master enable |
| aspm_ctl | input | 2 | Active-state control: bit 0 allows L0s, bit 1 allows L1 |
| ent_lat_sel | input | 1 | 1 = standby entry latency is one quarter of the partner exit latency |
| partner_exit_lat | input | LAT_W | Partner standby exit latency in cycles |
| l1_dwell | input | LAT_W | Cycles spent in L0s before L1 |
| l1_cap | input | 1 | Capability for active-state L1 |
| pme_en | input | 1 | Wake-event signalling enabled |
| pll_gate_dis | input | 1 | Blocks the PLL-gate request |
| act_req | input | 1 | Pending transmit or receive activity |
| link_state | output | 3 | Current link state |
| dev_state | output | 2 | Aggregate device state |
| pll_gate_req | output | 1 | Request to gate the link PLL |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before normal operation. They also assume that `aspm_ctl`, `l1_cap`, `pme_en` and the latency inputs are static levels rather than glitching strobes. The power-state writes are assumed to come only as one-cycle pulses. The stimulus changes every input just after a rising edge and holds it for whole cycles. It changes the latency and enable levels only while `act_req` holds the link in L0, and it applies function resets to all functions together when it wants the off path.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    DEV_OFF   = 2'd0,
    DEV_D0U   = 2'd1,
    DEV_D0A   = 2'd2,
    DEV_SLEEP = 2'd3
  } dev_st_e;

  typedef enum logic [2:0] {
    LNK_L0  = 3'd0,
    LNK_L0S = 3'd1,
    LNK_L1  = 3'd2,
    LNK_L2  = 3'd3,
    LNK_L3  = 3'd4
  } lnk_st_e;

  localparam logic [1:0] PM_CMD_WAKE  = 2'b00;
  localparam logic [1:0] PM_CMD_SLEEP = 2'b11;

  function automatic logic dev_awake(input logic [1:0] s);
    return (s == DEV_D0U) || (s == DEV_D0A);
  endfunction

endpackage

// File: rtl/lpm_fn_tracker.sv
module lpm_fn_tracker
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fn_rst,
  input  logic       pm_wr_en,
  input  logic [1:0] pm_wr_val,
  input  logic       bme,
  output logic [1:0] st_o
);

  dev_st_e st, st_nxt;

  always_comb begin
    st_nxt = st;
    if (fn_rst) begin
      st_nxt = DEV_OFF;
    end else begin
      unique case (st)
        DEV_OFF:   st_nxt = DEV_D0U;
        DEV_D0U: begin
          if (pm_wr_en && pm_wr_val == PM_CMD_SLEEP) st_nxt = DEV_SLEEP;
          else if (bme)                              st_nxt = DEV_D0A;
        end
        DEV_D0A: begin
          if (pm_wr_en && pm_wr_val == PM_CMD_SLEEP) st_nxt = DEV_SLEEP;
        end
        DEV_SLEEP: begin
          if (pm_wr_en && pm_wr_val == PM_CMD_WAKE) st_nxt = DEV_D0U;
        end
        default:   st_nxt = DEV_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= DEV_OFF;
    else        st <= st_nxt;
  end

  assign st_o = st;

  AST_FN_RST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fn_rst |=> st == DEV_OFF); // R2
  AST_FN_OFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DEV_OFF && !fn_rst) |=> st == DEV_D0U); // R2
  AST_FN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DEV_SLEEP && !fn_rst && pm_wr_en && pm_wr_val == PM_CMD_WAKE) |=> st == DEV_D0U); // R2

endmodule

// File: rtl/lpm_dev_agg.sv
module lpm_dev_agg
  import lpm_pkg::*;
#(
  parameter int NUM_FN = 4
) (
  input  logic [2*NUM_FN-1:0] fn_st,
  output logic [1:0]          agg_st
);

  logic any_d0a, any_d0u, any_slp;

  always_comb begin
    any_d0a = 1'b0;
    any_d0u = 1'b0;
    any_slp = 1'b0;
    for (int i = 0; i < NUM_FN; i++) begin
      if (fn_st[2*i +: 2] == DEV_D0A)   any_d0a = 1'b1;
      if (fn_st[2*i +: 2] == DEV_D0U)   any_d0u = 1'b1;
      if (fn_st[2*i +: 2] == DEV_SLEEP) any_slp = 1'b1;
    end
    if (any_d0a)      agg_st = DEV_D0A;
    else if (any_d0u) agg_st = DEV_D0U;
    else if (any_slp) agg_st = DEV_SLEEP;
    else              agg_st = DEV_OFF;
  end

endmodule

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         expired
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // limit is at least 1; expired marks the limit-th idle cycle
  assign expired = (cnt >= limit - 1'b1);

  AST_TMR_LIMIT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    limit != '0); // R5
  AST_TMR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R6

endmodule

// File: rtl/lpm_link_fsm.sv
module lpm_link_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] agg_st,
  input  logic       act_req,
  input  logic [1:0] aspm_ctl,
  input  logic       l1_cap,
  input  logic       pme_en,
  input  logic       ent_exp,
  input  logic       dwell_exp,
  output logic [2:0] lnk_o,
  output logic       ent_clr,
  output logic       dwell_clr
);

  lnk_st_e cur, nxt;
  dev_st_e last_agg;
  logic    awake;

  assign awake = dev_awake(agg_st);

  always_comb begin
    nxt = cur;
    if (agg_st == DEV_OFF) begin
      if (cur != LNK_L2 && cur != LNK_L3)
        nxt = (last_agg == DEV_SLEEP && pme_en) ? LNK_L2 : LNK_L3;
    end else if (agg_st == DEV_SLEEP) begin
      nxt = LNK_L1;
    end else begin
      unique case (cur)
        LNK_L0: begin
          if (!act_req && aspm_ctl[0] && ent_exp) nxt = LNK_L0S;
        end
        LNK_L0S: begin
          if (act_req)                                nxt = LNK_L0;
          else if (aspm_ctl[1] && l1_cap && dwell_exp) nxt = LNK_L1;
        end
        LNK_L1: begin
          if (act_req || last_agg == DEV_SLEEP) nxt = LNK_L0;
        end
        default: nxt = LNK_L0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= LNK_L3;
      last_agg <= DEV_OFF;
    end else begin
      cur      <= nxt;
      last_agg <= dev_st_e'(agg_st);
    end
  end

  assign ent_clr   = act_req || (cur != LNK_L0);
  assign dwell_clr = act_req || (cur != LNK_L0S);
  assign lnk_o     = cur;

  AST_SLEEP_TO_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (agg_st == DEV_SLEEP) |=> cur == LNK_L1); // R7
  AST_ACT_TO_L0: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && act_req && (cur == LNK_L0S || cur == LNK_L1)) |=> cur == LNK_L0); // R6
  AST_L0S_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == LNK_L0 && !aspm_ctl[0]) |=> cur != LNK_L0S); // R4
  AST_L1_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && !l1_cap && cur != LNK_L1) |=> cur != LNK_L1); // R8
  AST_NO_L3_TO_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == LNK_L3) |=> cur != LNK_L2); // R9

endmodule

// File: rtl/lpm_link_ctrl.sv
module lpm_link_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_FN = 4,
  parameter int LAT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FN-1:0]   fn_rst,
  input  logic [NUM_FN-1:0]   pm_wr_en,
  input  logic [2*NUM_FN-1:0] pm_wr_data,
  input  logic [NUM_FN-1:0]   bme,
  input  logic [1:0]          aspm_ctl,
  input  logic                ent_lat_sel,
  input  logic [LAT_W-1:0]    partner_exit_lat,
  input  logic [LAT_W-1:0]    l1_dwell,
  input  logic                l1_cap,
  input  logic                pme_en,
  input  logic                pll_gate_dis,
  input  logic                act_req,
  output logic [2:0]          link_state,
  output logic [1:0]          dev_state,
  output logic                pll_gate_req
);

  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  logic [2*NUM_FN-1:0] fn_st;
  logic [LAT_W-1:0]    ent_raw, ent_lim, dwell_lim;
  logic                ent_clr, dwell_clr, ent_exp, dwell_exp;

  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    lpm_fn_tracker u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .fn_rst    (fn_rst[g]),
      .pm_wr_en  (pm_wr_en[g]),
      .pm_wr_val (pm_wr_data[2*g +: 2]),
      .bme       (bme[g]),
      .st_o      (fn_st[2*g +: 2])
    );
  end

  lpm_dev_agg #(.NUM_FN(NUM_FN)) u_agg (
    .fn_st  (fn_st),
    .agg_st (dev_state)
  );

  assign ent_raw   = ent_lat_sel ? (partner_exit_lat >> 2) : partner_exit_lat;
  assign ent_lim   = (ent_raw == '0) ? LAT_ONE : ent_raw;
  assign dwell_lim = (l1_dwell == '0) ? LAT_ONE : l1_dwell;

  lpm_idle_timer #(.W(LAT_W)) u_ent_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ent_clr),
    .limit   (ent_lim),
    .expired (ent_exp)
  );

  lpm_idle_timer #(.W(LAT_W)) u_dwell_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (dwell_clr),
    .limit   (dwell_lim),
    .expired (dwell_exp)
  );

  lpm_link_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .agg_st    (dev_state),
    .act_req   (act_req),
    .aspm_ctl  (aspm_ctl),
    .l1_cap    (l1_cap),
    .pme_en    (pme_en),
    .ent_exp   (ent_exp),
    .dwell_exp (dwell_exp),
    .lnk_o     (link_state),
    .ent_clr   (ent_clr),
    .dwell_clr (dwell_clr)
  );

  assign pll_gate_req = !pll_gate_dis &&
                        (link_state == LNK_L1 || link_state == LNK_L2);

  AST_PLL_GATE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pll_gate_dis |-> !pll_gate_req); // R10
  AST_OFF_NO_GATE_L0: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == LNK_L0 || link_state == LNK_L3) |-> !pll_gate_req); // R10

endmodule

// File: tb/sim_lpm_link_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_link_ctrl;

  localparam int NF = 4;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] fn_rst, pm_wr_en, bme;
  logic [2*NF-1:0] pm_wr_data;
  logic [1:0]    aspm_ctl;
  logic          ent_lat_sel, l1_cap, pme_en, pll_gate_dis, act_req;
  logic [LW-1:0] partner_exit_lat, l1_dwell;
  logic [2:0]    link_state;
  logic [1:0]    dev_state;
  logic          pll_gate_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lpm_link_ctrl #(.NUM_FN(NF), .LAT_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .fn_rst(fn_rst), .pm_wr_en(pm_wr_en),
    .pm_wr_data(pm_wr_data), .bme(bme), .aspm_ctl(aspm_ctl),
    .ent_lat_sel(ent_lat_sel), .partner_exit_lat(partner_exit_lat),
    .l1_dwell(l1_dwell), .l1_cap(l1_cap), .pme_en(pme_en),
    .pll_gate_dis(pll_gate_dis), .act_req(act_req),
    .link_state(link_state), .dev_state(dev_state), .pll_gate_req(pll_gate_req)
  );

  // {fn_rst, bme, sleep-write mask, expected dev_state}
  localparam logic [15:0] AGG_VEC [8] = '{
    16'hF000, 16'h0001, 16'hE102, 16'h30C3,
    16'h10C1, 16'h00F3, 16'h04B2, 16'h8773
  };

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sleep_all();
    pm_wr_data = '1;
    pm_wr_en   = '1;
    step(1);
    pm_wr_en   = '0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fn_rst = '1; pm_wr_en = '0; pm_wr_data = '0; bme = '0;
    aspm_ctl = 2'b00; ent_lat_sel = 1'b0; partner_exit_lat = 16'd5;
    l1_dwell = 16'd3; l1_cap = 1'b1; pme_en = 1'b0; pll_gate_dis = 1'b0;
    act_req = 1'b1;
    step(3);
    rst_n = 1'b1;
    #1;
    chk("R3 reset link", link_state, 4);
    chk("R3 reset dev", dev_state, 0);
    chk("R10 reset pll", pll_gate_req, 0);

    // R1 R2 aggregation table
    for (int i = 0; i < 8; i++) begin
      fn_rst = '1;
      step(1);
      fn_rst = AGG_VEC[i][15:12];
      step(1);
      bme = AGG_VEC[i][11:8];
      step(1);
      bme = '0;
      pm_wr_data = '1;
      pm_wr_en = AGG_VEC[i][7:4];
      step(1);
      pm_wr_en = '0;
      chk("R1 aggregate", dev_state, int'(AGG_VEC[i][3:0]));
    end

    // bring up, link to L0
    fn_rst = '1; step(2);
    fn_rst = '0; step(1);
    chk("R2 off to uninit", dev_state, 1);
    step(1);
    chk("R9 off to L0", link_state, 0);

    // R4 standby entry after 5 idle edges
    aspm_ctl = 2'b01;
    act_req = 1'b0;
    step(4);
    chk("R4 before latency", link_state, 0);
    step(1);
    chk("R4 enter L0s", link_state, 1);
    step(6);
    chk("R7 L1 disabled holds L0s", link_state, 1);
    act_req = 1'b1; step(1);
    chk("R6 wake from L0s", link_state, 0);

    // R7 dwell into L1
    aspm_ctl = 2'b11;
    act_req = 1'b0;
    step(5);
    chk("R4 L0s again", link_state, 1);
    step(2);
    chk("R7 dwell not done", link_state, 1);
    step(1);
    chk("R7 enter L1", link_state, 2);
    chk("R10 pll in L1", pll_gate_req, 1);
    pll_gate_dis = 1'b1; #1;
    chk("R10 pll disabled", pll_gate_req, 0);
    pll_gate_dis = 1'b0;
    act_req = 1'b1; step(1);
    chk("R6 wake from L1", link_state, 0);

    // R8 no capability
    l1_cap = 1'b0; act_req = 1'b0;
    step(20);
    chk("R8 no L1 without cap", link_state, 1);
    act_req = 1'b1; step(1);
    l1_cap = 1'b1;

    // R5 quarter latency
    ent_lat_sel = 1'b1; partner_exit_lat = 16'd12; act_req = 1'b0;
    step(2);
    chk("R5 quarter not yet", link_state, 0);
    step(1);
    chk("R5 quarter entry", link_state, 1);
    act_req = 1'b1; step(1);
    partner_exit_lat = 16'd2; act_req = 1'b0;
    step(1);
    chk("R5 minimum one", link_state, 1);
    act_req = 1'b1; step(1);
    ent_lat_sel = 1'b0; partner_exit_lat = 16'd5;

    // R7 sleep, R9 aux power path
    sleep_all();
    chk("R1 all sleep", dev_state, 3);
    step(1);
    chk("R7 sleep to L1", link_state, 2);
    pme_en = 1'b1; fn_rst = '1;
    step(1);
    chk("R2 reset to off", dev_state, 0);
    step(1);
    chk("R9 sleep+pme to L2", link_state, 3);
    chk("R10 pll in L2", pll_gate_req, 1);
    step(3);
    chk("R9 L2 holds", link_state, 3);
    fn_rst = '0; step(2);
    chk("R9 L2 to L0", link_state, 0);
    fn_rst = '1; step(2);
    chk("R9 active reset to L3", link_state, 4);
    fn_rst = '0; step(2);
    pme_en = 1'b0;
    sleep_all(); step(1);
    chk("R7 sleep L1 again", link_state, 2);
    fn_rst = '1; step(2);
    chk("R9 no pme to L3", link_state, 4);
    chk("R10 pll in L3", pll_gate_req, 0);
    fn_rst = '0; step(2);

    // R11 wake from sleep without traffic
    aspm_ctl = 2'b00; act_req = 1'b0;
    sleep_all(); step(1);
    chk("R7 sleep L1 third", link_state, 2);
    pm_wr_data = '0; pm_wr_en = '1;
    step(1);
    pm_wr_en = '0;
    chk("R2 wake write", dev_state, 1);
    step(1);
    chk("R11 sleep exit to L0", link_state, 0);
    pm_wr_data = '0; pm_wr_en = '1;
    step(1);
    pm_wr_en = '0;
    chk("R2 wake write ignored in D0", dev_state, 1);
    bme = '1; step(1); bme = '0;
    chk("R2 bme to active", dev_state, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule